// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block decides when an analog-to-digital conversion begins and ends. It accepts two start sources. One is a software start request, a single-cycle pulse in the bus clock domain. The other is an asynchronous hardware trigger line, which the block synchronizes and watches for rising edges. A configuration bit selects which of the two sources is active.

Once a conversion is launched, the block counts converter-clock enables for a length set by the selected resolution. It then issues a one-cycle completion pulse. In continuous mode the block relaunches on its own on the following cycle. Trigger edges that arrive while it is busy are dropped and never queued.

The FSM has three states. `SEQ_IDLE` waits for a start. The transition idle→convert happens on an accepted start. `SEQ_CONVERT` counts enables. The transition convert→wrap happens on the last enable and raises the done pulse. `SEQ_WRAP` goes wrap→convert when continuous mode is still set, with a new start pulse, and wrap→idle otherwise.

Top module: `conv_trigger_ctrl`

## Requirements
- R1: After reset, `busy`, `conv_start` and `conv_done` are all low.
- R2: With `hw_trig_en` low, a `sw_start` pulse sampled while idle makes `conv_start` high for exactly one cycle, starting on the cycle after the sampling edge. `busy` rises at the same time.
- R3: With `hw_trig_en` high, `sw_start` is ignored: `busy` stays low and no `conv_start` appears.
- R4: With `hw_trig_en` high, a rising edge on `hw_trig_in` seen while idle produces `conv_start` on the third clock edge after the input changes. The input passes through a two-flop synchronizer and then an edge-detect flop.
- R5: With `hw_trig_en` low, edges on `hw_trig_in` are ignored.
- R6: `conv_done` rises one cycle after the last counted enable. The count of `conv_clk_en` cycles is taken from the `res_sel` value sampled at the start: 2'b00 = 8-bit = 17 enables, 2'b01 = 10-bit = 20 enables, 2'b10 and 2'b11 = 12-bit = 23 enables.
- R7: A hardware edge during a conversion, including the wrap cycle, is dropped. In single mode the block returns to idle after `conv_done` and stays there.
- R8: With `cont_mode` high, `conv_start` repeats on the cycle after each `conv_done`. Further trigger edges have no effect.
- R9: Clearing `cont_mode` during a conversion lets that conversion complete. `busy` then falls on the cycle after `conv_done`, and no further start follows.
- R10: The conversion counter only advances on cycles where `conv_clk_en` is high. While it is low, `busy` holds and no `conv_done` occurs.
- R11: `conv_start` and `conv_done` are single-cycle pulses and never high together. `busy` rises only with `conv_start` and falls only right after `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_trig_en | input | 1 | 1 selects the hardware trigger, 0 selects the software start |
| hw_trig_in | input | 1 | Asynchronous hardware trigger line |
| sw_start | input | 1 | Software start request pulse |
| cont_mode | input | 1 | Continuous conversion mode |
| res_sel | input | 2 | Resolution select (see R6) |
| conv_clk_en | input | 1 | Converter clock enable |
| busy | output | 1 | Conversion in progress |
| conv_start | output | 1 | One-cycle pulse at the beginning of each conversion |
| conv_done | output | 1 | One-cycle pulse at the end of each conversion |

## Verification
A software start shows on `conv_start` one edge after it is sampled. A hardware edge shows on the third edge, because of two synchronizer flops and one edge flop. `conv_done` follows the last counted enable by one edge, and in continuous mode the next `conv_start` follows `conv_done` by one more edge. The bench drives all inputs just after the falling edge and reads outputs on falling edges. A cycle-level reference model, fed the same inputs on the same rising edges, is compared against the outputs every cycle. Directed tests count falling edges between pulses and compare the count with these latencies.

// File: rtl/conv_trig_pkg.sv
package conv_trig_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_CONVERT = 2'd1,
        SEQ_WRAP    = 2'd2
    } seq_state_t;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    for (genvar i = 1; i < CHAIN; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
        end
    end

    // newest synchronized sample high, one older sample low
    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/conv_len_counter.sv
module conv_len_counter #(
    parameter int LEN_8B  = 17,
    parameter int LEN_10B = 20,
    parameter int LEN_12B = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] res_sel,
    input  logic       tick,
    output logic       last
);
    localparam int MAX_A = (LEN_8B > LEN_10B) ? LEN_8B : LEN_10B;
    localparam int MAX_L = (MAX_A > LEN_12B) ? MAX_A : LEN_12B;
    localparam int CNT_W = $clog2(MAX_L + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        unique case (res_sel)
            2'b00:   load_val = CNT_W'(LEN_8B);
            2'b01:   load_val = CNT_W'(LEN_10B);
            default: load_val = CNT_W'(LEN_12B);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (tick && !last) cnt_q <= cnt_q - 1'b1;
    end

    assign last = tick && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
    import conv_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cont_mode,
    input  logic last,
    output logic load,
    output logic active,
    output logic busy,
    output logic start_q,
    output logic done_q
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (go) begin
                    state_d = SEQ_CONVERT;
                    load    = 1'b1;
                end
            end
            SEQ_CONVERT: begin
                if (last) state_d = SEQ_WRAP;
            end
            SEQ_WRAP: begin
                if (cont_mode) begin
                    state_d = SEQ_CONVERT;
                    load    = 1'b1;
                end else begin
                    state_d = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            start_q <= load;
            done_q  <= last;
        end
    end

    assign active = (state_q == SEQ_CONVERT);
    assign busy   = (state_q != SEQ_IDLE);
endmodule

// File: rtl/conv_trigger_ctrl.sv
module conv_trigger_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int LEN_8B      = 17,
    parameter int LEN_10B     = 20,
    parameter int LEN_12B     = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_trig_en,
    input  logic       hw_trig_in,
    input  logic       sw_start,
    input  logic       cont_mode,
    input  logic [1:0] res_sel,
    input  logic       conv_clk_en,
    output logic       busy,
    output logic       conv_start,
    output logic       conv_done
);
    logic hw_rise;
    logic go;
    logic load;
    logic active;
    logic last;

    trig_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hw_trig_in),
        .rise     (hw_rise)
    );

    assign go = hw_trig_en ? hw_rise : sw_start;

    conv_len_counter #(
        .LEN_8B  (LEN_8B),
        .LEN_10B (LEN_10B),
        .LEN_12B (LEN_12B)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .res_sel (res_sel),
        .tick    (active & conv_clk_en),
        .last    (last)
    );

    conv_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .cont_mode (cont_mode),
        .last      (last),
        .load      (load),
        .active    (active),
        .busy      (busy),
        .start_q   (conv_start),
        .done_q    (conv_done)
    );
endmodule

// File: rtl/conv_trigger_ctrl_chk.sv
module conv_trigger_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic conv_start,
    input logic conv_done
);
    // R11
    start_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start && conv_done));

    // R11
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> conv_start);

    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(conv_done));

    // R8
    after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (!busy || conv_start));

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);
endmodule

bind conv_trigger_ctrl conv_trigger_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .conv_start (conv_start),
    .conv_done  (conv_done)
);

// File: tb/conv_trigger_ctrl_bench.sv
module conv_trigger_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_trig_en = 1'b0;
    logic       hw_trig_in = 1'b0;
    logic       sw_start = 1'b0;
    logic       cont_mode = 1'b0;
    logic [1:0] res_sel = 2'b00;
    logic       conv_clk_en = 1'b1;
    logic       busy, conv_start, conv_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    conv_trigger_ctrl u_conv_trigger_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_trig_en(hw_trig_en), .hw_trig_in(hw_trig_in),
        .sw_start(sw_start), .cont_mode(cont_mode), .res_sel(res_sel),
        .conv_clk_en(conv_clk_en), .busy(busy), .conv_start(conv_start),
        .conv_done(conv_done)
    );

    function automatic int exp_len(input logic [1:0] m);
        case (m)
            2'b00:   return 17;
            2'b01:   return 20;
            default: return 23;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle reference model built from the requirements
    logic m_s1, m_s2, m_s3;
    int   m_st, m_cnt;
    logic m_start, m_done;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
            m_st <= 0; m_cnt <= 0; m_start <= 0; m_done <= 0;
        end else begin
            m_s1 <= hw_trig_in; m_s2 <= m_s1; m_s3 <= m_s2;
            m_start <= 0; m_done <= 0;
            case (m_st)
                0: if (hw_trig_en ? (m_s2 && !m_s3) : sw_start) begin
                    m_st <= 1; m_cnt <= exp_len(res_sel); m_start <= 1;
                end
                1: if (conv_clk_en) begin
                    if (m_cnt == 1) begin m_done <= 1; m_st <= 2; end
                    else m_cnt <= m_cnt - 1;
                end
                default: if (cont_mode) begin
                    m_st <= 1; m_cnt <= exp_len(res_sel); m_start <= 1;
                end else m_st <= 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R11 start model", int'(conv_start), int'(m_start));
            check("R6 done model",   int'(conv_done),  int'(m_done));
            check("R7 busy model",   int'(busy),       int'(m_st != 0));
        end
    end

    task automatic step(); @(negedge clk); endtask

    task automatic wait_flag(input bit want_done, output int n);
        n = 0;
        do begin
            step(); n++;
        end while (!(want_done ? conv_done : conv_start) && n < 400);
    endtask

    task automatic sw_pulse();
        sw_start = 1'b1; step(); sw_start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (3) step();
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 start", int'(conv_start), 0);
        check("R1 done", int'(conv_done), 0);
        rst_n = 1'b1;
        step();

        // R2 / R6 software start, each resolution
        for (int m = 0; m < 4; m++) begin
            res_sel = 2'(m);
            sw_pulse();
            check("R2 start after sw", int'(conv_start), 1);
            check("R2 busy", int'(busy), 1);
            wait_flag(1'b1, n);
            check("R6 length", n, exp_len(2'(m)));
            step(); step();
        end
        res_sel = 2'b00;

        // R3 sw ignored with hw selected
        hw_trig_en = 1'b1;
        step();
        sw_pulse();
        repeat (4) step();
        check("R3 busy", int'(busy), 0);

        // R5 hw edge ignored with hw disabled
        hw_trig_en = 1'b0;
        hw_trig_in = 1'b1;
        repeat (6) step();
        check("R5 busy", int'(busy), 0);
        hw_trig_in = 1'b0;
        repeat (4) step();

        // R4 hw latency
        hw_trig_en = 1'b1;
        hw_trig_in = 1'b1;
        step(); check("R4 cycle1", int'(conv_start), 0);
        step(); check("R4 cycle2", int'(conv_start), 0);
        step(); check("R4 cycle3", int'(conv_start), 1);
        // R7 edge during conversion dropped
        repeat (3) step();
        hw_trig_in = 1'b0;
        repeat (2) step();
        hw_trig_in = 1'b1;
        wait_flag(1'b1, n);
        hw_trig_in = 1'b0;
        step();
        check("R7 idle after done", int'(busy), 0);
        n = 0;
        for (int i = 0; i < 10; i++) begin step(); n += int'(conv_start); end
        check("R7 no queued start", n, 0);

        // R8 continuous launch, edges ignored
        cont_mode = 1'b1;
        hw_trig_in = 1'b1;
        wait_flag(1'b0, n);
        for (int k = 0; k < 2; k++) begin
            n = 0;
            do begin
                step(); n++;
                if (n == 4) hw_trig_in = 1'b0;
                if (n == 8) hw_trig_in = 1'b1;
            end while (!conv_start && n < 400);
            check("R8 restart period", n, exp_len(2'b00) + 1);
        end
        // R9 clear continuous mid-conversion
        repeat (3) step();
        cont_mode = 1'b0;
        wait_flag(1'b1, n);
        check("R9 finishes", n, exp_len(2'b00) - 3);
        step();
        check("R9 idle", int'(busy), 0);
        n = 0;
        for (int i = 0; i < 6; i++) begin step(); n += int'(conv_start); end
        check("R9 no restart", n, 0);
        hw_trig_in = 1'b0;

        // R10 enable gating
        hw_trig_en = 1'b0;
        repeat (3) step();
        sw_pulse();
        n = 0;
        for (int i = 0; i < 3; i++) step();
        conv_clk_en = 1'b0;
        for (int i = 0; i < 40; i++) begin step(); n += int'(conv_done); end
        check("R10 no done while gated", n, 0);
        check("R10 busy held", int'(busy), 1);
        conv_clk_en = 1'b1;
        wait_flag(1'b1, n);
        check("R10 remaining enables", n, exp_len(2'b00) - 3);
        repeat (3) step();

        // random phase, compared each cycle by the model (R11)
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) < 10) hw_trig_in = ~hw_trig_in;
            sw_start = ($urandom_range(99) < 5);
            if ($urandom_range(99) < 2) hw_trig_en = ~hw_trig_en;
            if ($urandom_range(99) < 2) cont_mode = ~cont_mode;
            if ($urandom_range(99) < 3) res_sel = 2'($urandom_range(3));
            conv_clk_en = ($urandom_range(99) < 70);
            step();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule